// File: doc/BRIEF.md
# Fuse PROM Word Programming Sequencer

This block steps a one-time, fuse-type PROM through the pin sequence needed to burn one word. A fresh cell reads zero and can only be turned into a one. After a start strobe, the block takes in a target address and data word. It first reads the word back and then works through the bits that still read zero but should be one, one bit per pulse. Each pulse is wrapped in a fixed series of pin moves, with a settling delay between every move: outputs disabled, program strobe low, programming supply requested, the selected output pulled low for the pulse width, the supply dropped, the program strobe raised and the outputs enabled again. The block then reads the device outputs back.

Each group of pulses is called a pass. After a pass, the block compares the whole word with the target. Only the bits that still fail are pulsed again, in the next pass. A word that still fails after eight passes is reported as a reject. A word that shows a one where the target holds a zero cannot be repaired, so it is rejected at once. Every delay is a parameter in clock cycles. The supply ramp and the analog levels are outside this block: it only raises a request line and waits the programmed number of cycles.

Top module: `prom_burn_seq`

## Requirements
- R1: Out of reset and whenever idle: chip enable high, program strobe high, output enable (active low) low, supply request low, no pull-low bit active, busy low, done low.
- R2: A start strobe seen while idle captures the address and data. The address output holds that value unchanged until the word completes. A start strobe while busy is ignored.
- R3: The address is presented for TD_CYC cycles before chip enable falls.
- R4: A pull-low drive is active only while chip enable is low, output enable is high (outputs off), the program strobe is low and the supply request is high.
- R5: At most one pull-low bit is active at a time, and each pulse lasts exactly TPW_CYC cycles.
- R6: The supply request rises only while the program strobe is low and the outputs are off. The program strobe rises only after the supply request has dropped.
- R7: Only bits whose target is one and that read zero at the last verify are pulsed. A target that already matches the word finishes with no pulse and no reject.
- R8: A bit that reads one while its target bit is zero gives a reject with no further pulse.
- R9: A bit that needs k pulses, with k of eight or fewer, gets exactly k pulses and the word succeeds. A bit still reading zero after eight passes gives a reject after exactly eight pulses on that bit.
- R10: Busy is high from the cycle after an accepted start through the done cycle. Done is a one-cycle pulse. Reject is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| addr_i | input | ADDR_W | Word address to program |
| data_i | input | DATA_W | Target word (ones are bits to burn) |
| dev_q_i | input | DATA_W | Device data outputs, sampled at verify |
| mem_addr_o | output | ADDR_W | Address driven to the device |
| ce_n_o | output | 1 | Device chip enable, active low |
| oe_n_o | output | 1 | Device output enable, active low |
| prog_n_o | output | 1 | Device program strobe, active low |
| vpp_req_o | output | 1 | Request for the programming supply level |
| pull_lo_o | output | DATA_W | Per-bit pull-low drive on the device outputs |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reject_o | output | 1 | Word rejected, valid with done |

## Verification
The hardest case to reach is the eighth-pass boundary. Here one bit must succeed on exactly its eighth pulse, while in another word a bit never takes and a second bit in the same word programs early. The bench includes a behavioural PROM model in which each bit carries its own pulse count before the fuse blows, plus a "never" value. The vector table picks these counts to land on either side of the limit. It also covers a word that is already one where it should be zero, a word that already matches, and a start strobe issued in the middle of a run.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_CE,
    S_READ,
    S_OE_OFF,
    S_PROG_LO,
    S_VPP_UP,
    S_PULSE,
    S_RELEASE,
    S_VPP_DN,
    S_PROG_HI,
    S_OE_ON,
    S_CHECK,
    S_DONE
  } seq_state_t;

endpackage

// File: rtl/prom_rst_sync.sv
module prom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];

endmodule

// File: rtl/prom_dly_timer.sv
module prom_dly_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (load_i)                cnt_nx = val_i;
    else if (cnt_q != '0)      cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/prom_lsb_pick.sv
module prom_lsb_pick #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] one_o
);

  always_comb begin
    logic seen;
    seen  = 1'b0;
    one_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (req_i[i] && !seen) begin
        one_o[i] = 1'b1;
        seen     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prom_word_cmp.sv
module prom_word_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] target_i,
  input  logic [W-1:0] read_i,
  output logic [W-1:0] miss_o,
  output logic         extra_o
);

  logic [W-1:0] extra_bits;

  for (genvar g = 0; g < int'(W); g++) begin : g_bit
    assign miss_o[g]     = target_i[g] & ~read_i[g];
    assign extra_bits[g] = read_i[g] & ~target_i[g];
  end

  assign extra_o = |extra_bits;

endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
  import prom_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TD_CYC   = 200,
  parameter int unsigned TR_CYC   = 2000,
  parameter int unsigned TF_CYC   = 2000,
  parameter int unsigned TPW_CYC  = 20000,
  parameter int unsigned MAX_PASS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] dev_q_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              prog_n_o,
  output logic              vpp_req_o,
  output logic [DATA_W-1:0] pull_lo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              reject_o
);

  localparam int unsigned UP_CYC  = TR_CYC + TD_CYC;
  localparam int unsigned MAX_A   = (UP_CYC > TPW_CYC) ? UP_CYC : TPW_CYC;
  localparam int unsigned MAX_DLY = (MAX_A > TF_CYC) ? MAX_A : TF_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);
  localparam int unsigned PASS_W  = $clog2(MAX_PASS) + 1;

  logic rst_n_s;

  seq_state_t        state_q, state_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] pass_mask_q, pass_mask_nx;
  logic [PASS_W-1:0] pass_cnt_q, pass_cnt_nx;
  logic              rej_q, rej_nx;
  logic              cap_en;
  logic              pass_en;

  logic              tmr_ld;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;

  logic [DATA_W-1:0] cur_bit;
  logic [DATA_W-1:0] miss_bits;
  logic              extra_bit;
  logic [DATA_W-1:0] rest_mask;

  prom_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  prom_dly_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_i    (tmr_ld),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  prom_lsb_pick #(.W(DATA_W)) u_pick (
    .req_i (pass_mask_q),
    .one_o (cur_bit)
  );

  prom_word_cmp #(.W(DATA_W)) u_cmp (
    .target_i (data_q),
    .read_i   (dev_q_i),
    .miss_o   (miss_bits),
    .extra_o  (extra_bit)
  );

  function automatic logic [CNT_W-1:0] dly_of(seq_state_t s);
    case (s)
      S_ADDR, S_CE, S_OE_OFF, S_PROG_LO,
      S_RELEASE, S_PROG_HI, S_OE_ON: return CNT_W'(TD_CYC - 1);
      S_VPP_UP:                      return CNT_W'(UP_CYC - 1);
      S_PULSE:                       return CNT_W'(TPW_CYC - 1);
      S_VPP_DN:                      return CNT_W'(TF_CYC - 1);
      default:                       return '0;
    endcase
  endfunction

  assign rest_mask = pass_mask_q & ~cur_bit;

  // next-state logic
  always_comb begin
    state_nx     = state_q;
    pass_mask_nx = pass_mask_q;
    pass_cnt_nx  = pass_cnt_q;
    rej_nx       = rej_q;
    cap_en       = 1'b0;
    pass_en      = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          cap_en   = 1'b1;
          rej_nx   = 1'b0;
          state_nx = S_ADDR;
        end
      end
      S_ADDR:    if (tmr_exp) state_nx = S_CE;
      S_CE:      if (tmr_exp) state_nx = S_READ;
      S_READ: begin
        pass_en = 1'b1;
        if (extra_bit) begin
          rej_nx   = 1'b1;
          state_nx = S_DONE;
        end else if (miss_bits == '0) begin
          state_nx = S_DONE;
        end else begin
          pass_mask_nx = miss_bits;
          pass_cnt_nx  = '0;
          state_nx     = S_OE_OFF;
        end
      end
      S_OE_OFF:  if (tmr_exp) state_nx = S_PROG_LO;
      S_PROG_LO: if (tmr_exp) state_nx = S_VPP_UP;
      S_VPP_UP:  if (tmr_exp) state_nx = S_PULSE;
      S_PULSE:   if (tmr_exp) state_nx = S_RELEASE;
      S_RELEASE: if (tmr_exp) state_nx = S_VPP_DN;
      S_VPP_DN:  if (tmr_exp) state_nx = S_PROG_HI;
      S_PROG_HI: if (tmr_exp) state_nx = S_OE_ON;
      S_OE_ON:   if (tmr_exp) state_nx = S_CHECK;
      S_CHECK: begin
        pass_en = 1'b1;
        if (extra_bit) begin
          rej_nx   = 1'b1;
          state_nx = S_DONE;
        end else if (rest_mask != '0) begin
          pass_mask_nx = rest_mask;
          state_nx     = S_OE_OFF;
        end else if (miss_bits == '0) begin
          pass_mask_nx = '0;
          state_nx     = S_DONE;
        end else if (pass_cnt_q == PASS_W'(MAX_PASS - 1)) begin
          pass_mask_nx = '0;
          rej_nx       = 1'b1;
          state_nx     = S_DONE;
        end else begin
          pass_mask_nx = miss_bits;
          pass_cnt_nx  = pass_cnt_q + 1'b1;
          state_nx     = S_OE_OFF;
        end
      end
      S_DONE:    state_nx = S_IDLE;
      default:   state_nx = S_IDLE;
    endcase
  end

  assign tmr_ld  = (state_nx != state_q);
  assign tmr_val = dly_of(state_nx);

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      rej_q   <= rej_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pass_mask_q <= '0;
      pass_cnt_q  <= '0;
    end else if (pass_en) begin
      pass_mask_q <= pass_mask_nx;
      pass_cnt_q  <= pass_cnt_nx;
    end
  end

  // pin decode
  always_comb begin
    ce_n_o    = 1'b1;
    oe_n_o    = 1'b0;
    prog_n_o  = 1'b1;
    vpp_req_o = 1'b0;
    pull_lo_o = '0;
    case (state_q)
      S_CE, S_READ, S_OE_ON, S_CHECK: ce_n_o = 1'b0;
      S_OE_OFF: begin
        ce_n_o = 1'b0;
        oe_n_o = 1'b1;
      end
      S_PROG_LO: begin
        ce_n_o   = 1'b0;
        oe_n_o   = 1'b1;
        prog_n_o = 1'b0;
      end
      S_VPP_UP, S_RELEASE, S_VPP_DN: begin
        ce_n_o    = 1'b0;
        oe_n_o    = 1'b1;
        prog_n_o  = 1'b0;
        vpp_req_o = (state_q != S_VPP_DN);
      end
      S_PULSE: begin
        ce_n_o    = 1'b0;
        oe_n_o    = 1'b1;
        prog_n_o  = 1'b0;
        vpp_req_o = 1'b1;
        pull_lo_o = cur_bit;
      end
      S_PROG_HI: begin
        ce_n_o = 1'b0;
        oe_n_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_addr_o = addr_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign reject_o   = (state_q == S_DONE) && rej_q;

endmodule

// File: rtl/prom_burn_seq_chk.sv
module prom_burn_seq_chk #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TPW_CYC = 20000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              ce_n_o,
  input logic              oe_n_o,
  input logic              prog_n_o,
  input logic              vpp_req_o,
  input logic [DATA_W-1:0] pull_lo_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              reject_o
);

  logic [31:0] pw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pw_q <= '0;
    else if (|pull_lo_o) pw_q <= pw_q + 1'b1;
    else                 pw_q <= '0;
  end

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (ce_n_o && prog_n_o && !oe_n_o && !vpp_req_o && pull_lo_o == '0 && !done_o));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

  a_r4_pull_window: assert property (@(posedge clk) disable iff (!rst_n)
    (|pull_lo_o) |-> (!ce_n_o && oe_n_o && !prog_n_o && vpp_req_o));

  a_r5_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pull_lo_o));

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|pull_lo_o) && pw_q != '0) |-> (pw_q == TPW_CYC));

  a_r6_vpp_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_req_o) |-> (!prog_n_o && oe_n_o));

  a_r6_prog_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) |-> !vpp_req_o);

  a_r10_reject_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> done_o);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind prom_burn_seq prom_burn_seq_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .TPW_CYC (TPW_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_addr_o (mem_addr_o),
  .ce_n_o     (ce_n_o),
  .oe_n_o     (oe_n_o),
  .prog_n_o   (prog_n_o),
  .vpp_req_o  (vpp_req_o),
  .pull_lo_o  (pull_lo_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .reject_o   (reject_o)
);

// File: tb/prom_burn_seq_tb.sv
`timescale 1ns/1ps
module prom_burn_seq_tb_top;

  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int TD  = 3;
  localparam int TR  = 5;
  localparam int TF  = 4;
  localparam int TPW = 10;

  // {addr[4], data[8], init[8], needs[32]}; needs nibble i = pulses bit i needs, 15 = never
  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {4'd1, 8'hA5, 8'h00, 32'h1111_1111},
    {4'd2, 8'hFF, 8'h0F, 32'h3333_3333},
    {4'd3, 8'h3C, 8'h3C, 32'h0000_0000},
    {4'd4, 8'h01, 8'h00, 32'h0000_0008},
    {4'd5, 8'h81, 8'h00, 32'h9000_0002},
    {4'd6, 8'h0F, 8'h10, 32'h1111_1111},
    {4'd7, 8'h00, 8'h00, 32'h0000_0000},
    {4'd8, 8'h50, 8'h40, 32'h000F_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] data_i;
  logic [DW-1:0] dev_q;
  logic [AW-1:0] mem_addr_o;
  logic          ce_n_o, oe_n_o, prog_n_o, vpp_req_o;
  logic [DW-1:0] pull_lo_o;
  logic          busy_o, done_o, reject_o;

  int n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;

  // device model, written only in the monitor
  logic [DW-1:0] fuse [16];
  logic [3:0]    rem  [DW];
  int            pulse_tot;
  int            pw;
  logic [DW-1:0] last_pull;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_init;
  logic [31:0]   ld_need;
  logic [DW-1:0] cur_tgt;

  always #2.5 clk = ~clk;

  prom_burn_seq #(
    .ADDR_W(AW), .DATA_W(DW), .TD_CYC(TD), .TR_CYC(TR),
    .TF_CYC(TF), .TPW_CYC(TPW), .MAX_PASS(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .data_i(data_i), .dev_q_i(dev_q), .mem_addr_o(mem_addr_o),
    .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .prog_n_o(prog_n_o),
    .vpp_req_o(vpp_req_o), .pull_lo_o(pull_lo_o), .busy_o(busy_o),
    .done_o(done_o), .reject_o(reject_o)
  );

  assign dev_q = (!ce_n_o && !oe_n_o) ? fuse[mem_addr_o] : '0;

  always @(posedge clk) begin
    if (ld_en) begin
      fuse[ld_addr] <= ld_init;
      for (int i = 0; i < DW; i++) rem[i] <= ld_need[4*i +: 4];
      pulse_tot <= 0;
      pw        <= 0;
    end else if (|pull_lo_o) begin
      if (pw == 0) begin
        mon_chk++;
        if ((pull_lo_o & ~(cur_tgt & ~fuse[mem_addr_o])) != '0) begin
          mon_err++;
          $display("FAIL R7: pulsed bits %h, target %h, fuse %h", pull_lo_o, cur_tgt, fuse[mem_addr_o]);
        end
      end
      last_pull <= pull_lo_o;
      pw <= pw + 1;
    end else if (pw != 0) begin
      mon_chk++;
      if (pw != TPW) begin
        mon_err++;
        $display("FAIL R5: pulse width %0d expected %0d", pw, TPW);
      end
      pw        <= 0;
      pulse_tot <= pulse_tot + 1;
      for (int i = 0; i < DW; i++) begin
        if (last_pull[i] && rem[i] != 4'd15 && rem[i] != 4'd0) begin
          rem[i] <= rem[i] - 4'd1;
          if (rem[i] == 4'd1) fuse[mem_addr_o][i] <= 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [AW-1:0] a, input logic [DW-1:0] init,
                           input logic [31:0] need, input logic [DW-1:0] tgt);
    @(negedge clk);
    ld_addr = a; ld_init = init; ld_need = need; cur_tgt = tgt; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output bit rej, output bit ok_to);
    int  cyc;
    bit  busy_ok;
    @(negedge clk);
    addr_i = a; data_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1; busy_ok = 1'b1;
    while (!done_o && cyc < 20000) begin
      if (!busy_o) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    ok_to = done_o;
    rej   = reject_o;
    chk(busy_ok && busy_o, "R10 busy through run", busy_o, 1);
    @(negedge clk);
    chk(!done_o && !busy_o, "R10 single done", done_o, 0);
  endtask

  initial begin : watchdog
    #900000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err + mon_err, n_chk + mon_chk);
    $finish;
  end

  initial begin : main
    bit rej, fin;
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; data_i = '0; cur_tgt = '0;
    for (int i = 0; i < 16; i++) begin
      ld_addr = AW'(i); ld_init = '0; ld_need = '0; ld_en = 1'b1;
      @(posedge clk); #1;
    end
    ld_en = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ce_n_o && prog_n_o && !oe_n_o && !vpp_req_o && pull_lo_o == 0 && !busy_o && !done_o,
        "R1 reset pins", {ce_n_o, prog_n_o, oe_n_o, vpp_req_o, busy_o}, 5'b11000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table-driven words: R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d, init;
      logic [31:0]   need;
      int  exp_p;
      bit  exp_rej;
      a = VEC[v][51:48]; d = VEC[v][47:40]; init = VEC[v][39:32]; need = VEC[v][31:0];
      exp_rej = |(init & ~d);
      exp_p   = 0;
      if (!exp_rej) begin
        for (int i = 0; i < DW; i++) begin
          if (d[i] && !init[i]) begin
            if (need[4*i +: 4] > 4'd8) begin exp_p += 8; exp_rej = 1'b1; end
            else exp_p += int'(need[4*i +: 4]);
          end
        end
      end
      load_word(a, init, need, d);
      run_word(a, d, rej, fin);
      chk(fin, "R10 done seen", fin, 1);
      chk(rej == exp_rej, "R8/R9 reject flag", rej, exp_rej);
      chk(pulse_tot == exp_p, "R7/R9 pulse count", pulse_tot, exp_p);
      if (!exp_rej) chk(fuse[a] == d, "R7 word programmed", fuse[a], d);
    end

    // R3: address lead before chip enable
    begin
      int lead;
      load_word(4'd11, 8'h00, 32'h0, 8'h00);
      @(negedge clk);
      addr_i = 4'd11; data_i = 8'h00; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; lead = 0;
      while (busy_o && ce_n_o && lead < 100) begin
        chk(mem_addr_o == 4'd11, "R2 address presented", mem_addr_o, 11);
        lead++;
        @(negedge clk);
      end
      chk(lead == TD, "R3 address lead cycles", lead, TD);
      while (busy_o) @(negedge clk);
    end

    // R2: start while busy is ignored
    begin
      load_word(4'd9, 8'h00, 32'h1111_1111, 8'h06);
      @(negedge clk);
      addr_i = 4'd9; data_i = 8'h06; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (6) @(negedge clk);
      addr_i = 4'd10; data_i = 8'hFF; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(mem_addr_o == 4'd9, "R2 address held after busy start", mem_addr_o, 9);
      while (!done_o) @(negedge clk);
      chk(!reject_o, "R2 original word ok", reject_o, 0);
      chk(pulse_tot == 2, "R2 original pulse count", pulse_tot, 2);
      chk(fuse[9] == 8'h06 && fuse[10] == 8'h00, "R2 only original word burned", fuse[10], 0);
      @(negedge clk);
      chk(!busy_o, "R2 no second run", busy_o, 0);
    end

    // R1: reset in the middle of a pulse
    begin
      load_word(4'd12, 8'h00, 32'h0000_0009, 8'h01);
      @(negedge clk);
      addr_i = 4'd12; data_i = 8'h01; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (pull_lo_o == '0) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(!vpp_req_o && pull_lo_o == 0 && ce_n_o && prog_n_o && !busy_o,
          "R1 mid-run reset pins", {vpp_req_o, busy_o}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!busy_o && !done_o, "R1 idle after reset", busy_o, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err + mon_err, n_chk + mon_chk);
    $finish;
  end

endmodule